// File: doc/BRIEF.md
# Single-Cycle Byte/Word Reader over a Dual-Port Byte Memory

This block sits in front of a byte-wide, dual-ported storage array and lets one client fetch either a single byte or a 16-bit word with the same one-cycle latency. For a byte fetch only the first port is used. For a word fetch the first port is given the even address and the second port the next address in the same cycle. The two bytes that come back are joined, with the even-address byte in the low half.

Writes are one byte at a time and go through the first port only. A write shares the request address. It is refused whenever the same cycle carries a word request, because that request already occupies both ports. A word request at an odd address is refused: an error strobe is raised and the previously presented result stays on the output.

Top module: `bwr_byte_word_reader`

## Requirements
- R1: While reset is held, rd_valid and err are 0 and rd_data is 16'h0000.
- R2: A request with req_valid=1 and req_word=0 (byte) raises rd_valid in the next cycle, with rd_data = {8'h00, byte at req_addr}.
- R3: A request with req_valid=1, req_word=1 and req_addr[0]=0 raises rd_valid in the next cycle, with rd_data[7:0] = byte at req_addr and rd_data[15:8] = byte at req_addr+1.
- R4: A request with req_valid=1, req_word=1 and req_addr[0]=1 raises err for one cycle in the next cycle, keeps rd_valid at 0 and leaves rd_data unchanged.
- R5: With wr_en=1 and no word request in that cycle, wr_data is stored at req_addr, and a read in any later cycle returns it on either half of the result.
- R6: A write in a cycle where req_valid=1 and req_word=1 is dropped: the memory byte at req_addr keeps its old value.
- R7: A byte read and a write to the same address in the same cycle return the byte held before the write.
- R8: In a cycle with no accepted read (idle, write only, or refused word request), rd_valid is 0 in the next cycle and rd_data keeps its value.
- R9: A word read at the highest even address (DEPTH-2) returns the bytes at DEPTH-2 and DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_word | input | 1 | 1 = 16-bit word read, 0 = byte read |
| req_addr | input | 12 | Byte address for the read or write |
| wr_en | input | 1 | Byte write enable |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 16 | Result, held until the next accepted read |
| rd_valid | output | 1 | One-cycle strobe for a new result |
| err | output | 1 | One-cycle strobe for a refused odd-address word read |

## Verification
The bench builds the block with its default parameters, an 8-bit byte and 4096 entries, so the real 12-bit address range is in use. That puts the top pair of locations, 4094 and 4095, within reach, and the word read there checks that the second port's address is built at the array's edge without wrapping. The same-cycle collisions are driven at chosen addresses: a write with a word read, a write with a byte read, and a write followed at once by a word read through the second port.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_kind_t;

    typedef struct packed {
        logic rd_byte;
        logic rd_word;
        logic misaligned;
        logic wr;
    } bwr_cmd_t;

endpackage

// File: rtl/bwr_dp_mem.sv
module bwr_dp_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4096,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_q,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_q
);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) begin
            store[a_addr] <= a_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (a_en) begin
                a_q <= store[a_addr];
            end
            if (b_en) begin
                b_q <= store[b_addr];
            end
        end
    end

    // R3: second port always serves the neighbour of the first port's even address
    assert_adjacent_ports_R3: assert property (@(posedge clk) disable iff (rst)
        b_en |-> (a_en && !a_addr[0] && (b_addr == a_addr + 1'b1)));

    // R6: no write while both ports are busy with a word
    assert_no_write_on_word_R6: assert property (@(posedge clk) disable iff (rst)
        b_en |-> !a_we);

endmodule

// File: rtl/bwr_req_ctrl.sv
module bwr_req_ctrl
    import bwr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 12
) (
    input  logic              req_valid,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output bwr_cmd_t          cmd,
    output logic              a_en,
    output logic              a_we,
    output logic [ADDR_W-1:0] a_addr,
    output logic [DATA_W-1:0] a_wdata,
    output logic              b_en,
    output logic [ADDR_W-1:0] b_addr
);

    logic word_req;

    always_comb begin
        word_req       = req_valid && req_word;
        cmd.misaligned = word_req && req_addr[0];
        cmd.rd_word    = word_req && !req_addr[0];
        cmd.rd_byte    = req_valid && !req_word;
        cmd.wr         = wr_en && !word_req;

        a_en    = cmd.rd_byte || cmd.rd_word;
        a_we    = cmd.wr;
        a_addr  = req_addr;
        a_wdata = wr_data;
        b_en    = cmd.rd_word;
        b_addr  = {req_addr[ADDR_W-1:1], 1'b1};
    end

endmodule

// File: rtl/bwr_result.sv
module bwr_result
    import bwr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  bwr_cmd_t            cmd,
    input  logic [DATA_W-1:0]   a_q,
    input  logic [DATA_W-1:0]   b_q,
    output logic [2*DATA_W-1:0] rd_data,
    output logic                rd_valid,
    output logic                err
);

    acc_kind_t kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= ACC_BYTE;
            rd_valid <= 1'b0;
            err      <= 1'b0;
        end else begin
            rd_valid <= cmd.rd_byte || cmd.rd_word;
            err      <= cmd.misaligned;
            if (cmd.rd_word) begin
                kind_q <= ACC_WORD;
            end else if (cmd.rd_byte) begin
                kind_q <= ACC_BYTE;
            end
        end
    end

    assign rd_data = {(kind_q == ACC_WORD) ? b_q : {DATA_W{1'b0}}, a_q};

    // R2, R3: accepted read produces a strobe one cycle later
    assert_valid_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd_byte || cmd.rd_word) |=> (rd_valid && !err));

    // R4: refused word read gives error and no strobe
    assert_err_on_odd_word_R4: assert property (@(posedge clk) disable iff (rst)
        cmd.misaligned |=> (err && !rd_valid));

endmodule

// File: rtl/bwr_byte_word_reader.sv
module bwr_byte_word_reader
    import bwr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4096,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int RES_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [RES_W-1:0]  rd_data,
    output logic              rd_valid,
    output logic              err
);

    bwr_cmd_t          cmd;
    logic              a_en, a_we, b_en;
    logic [ADDR_W-1:0] a_addr, b_addr;
    logic [DATA_W-1:0] a_wdata, a_q, b_q;

    bwr_req_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
        .req_valid (req_valid),
        .req_word  (req_word),
        .req_addr  (req_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cmd       (cmd),
        .a_en      (a_en),
        .a_we      (a_we),
        .a_addr    (a_addr),
        .a_wdata   (a_wdata),
        .b_en      (b_en),
        .b_addr    (b_addr)
    );

    bwr_dp_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) mem_i (
        .clk     (clk),
        .rst     (rst),
        .a_en    (a_en),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .a_q     (a_q),
        .b_en    (b_en),
        .b_addr  (b_addr),
        .b_q     (b_q)
    );

    bwr_result #(.DATA_W(DATA_W)) res_i (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .a_q      (a_q),
        .b_q      (b_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .err      (err)
    );

    // R8: result holds across cycles without an accepted read
    assert_hold_without_read_R8: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !(req_word && req_addr[0])) |=> ($stable(rd_data) && !rd_valid));

endmodule

// File: tb/bwr_byte_word_reader_tb_top.sv
`timescale 1ns/1ps
module bwr_byte_word_reader_tb_top;

    typedef struct {
        logic        valid;
        logic        err;
        logic [15:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_word = 1'b0;
    logic [11:0] req_addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        err;

    int checks = 0;
    int fails  = 0;
    bit started = 1'b0;
    bit done = 1'b0;
    exp_t q[$];
    logic [7:0]  model [4096];
    logic [15:0] last = 16'h0000;

    always #2.5 clk = ~clk;

    bwr_byte_word_reader dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_word(req_word),
        .req_addr(req_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .err(err)
    );

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got {valid,err,data}=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input string tag, input logic rv, input logic wd,
                      input logic [11:0] ad, input logic we, input logic [7:0] wdat);
        exp_t e;
        @(negedge clk);
        req_valid = rv; req_word = wd; req_addr = ad; wr_en = we; wr_data = wdat;
        e.tag = tag;
        e.err = rv && wd && ad[0];
        e.valid = rv && !e.err;
        if (e.valid) begin
            last = wd ? {model[{ad[11:1], 1'b1}], model[ad]} : {8'h00, model[ad]};
        end
        e.data = last;
        if (we && !(rv && wd)) model[ad] = wdat;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        if (started) begin
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, {rd_valid, err, rd_data}, {e.valid, e.err, e.data});
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            check("R1 reset", {rd_valid, err, rd_data}, 18'h0);
        end
        @(negedge clk);
        rst = 1'b0;
        started = 1'b1;

        op("R5 write 0",    0, 0, 12'd0,    1, 8'h11);
        op("R5 write 1",    0, 0, 12'd1,    1, 8'h22);
        op("R5 write 4094", 0, 0, 12'd4094, 1, 8'hA5);
        op("R5 write 4095", 0, 0, 12'd4095, 1, 8'h5A);
        op("R5 write 100",  0, 0, 12'd100,  1, 8'h3C);
        op("R5 write 101",  0, 0, 12'd101,  1, 8'hC3);
        op("R5 write 6",    0, 0, 12'd6,    1, 8'h66);
        op("R5 write 7",    0, 0, 12'd7,    1, 8'h77);

        op("R2 byte 0",     1, 0, 12'd0,    0, 8'h00);
        op("R2 byte 1",     1, 0, 12'd1,    0, 8'h00);
        op("R2 byte 4095",  1, 0, 12'd4095, 0, 8'h00);
        op("R3 word 0",     1, 1, 12'd0,    0, 8'h00);
        op("R3 word 100",   1, 1, 12'd100,  0, 8'h00);
        op("R9 word 4094",  1, 1, 12'd4094, 0, 8'h00);
        op("R2 byte after word", 1, 0, 12'd7, 0, 8'h00);
        op("R3 word 6",     1, 1, 12'd6,    0, 8'h00);
        op("R4 odd word 7", 1, 1, 12'd7,    0, 8'h00);
        op("R4 odd word 4095", 1, 1, 12'd4095, 0, 8'h00);
        op("R8 idle",       0, 0, 12'd0,    0, 8'h00);
        op("R8 write only", 0, 0, 12'd200,  1, 8'hEE);
        op("R2 byte 200",   1, 0, 12'd200,  0, 8'h00);

        op("R6 write with word", 1, 1, 12'd100, 1, 8'hFF);
        op("R6 byte 100 kept",   1, 0, 12'd100, 0, 8'h00);
        op("R6 odd word with write", 1, 1, 12'd101, 1, 8'h99);
        op("R6 byte 101 kept",   1, 0, 12'd101, 0, 8'h00);

        op("R7 byte with write", 1, 0, 12'd0, 1, 8'h99);
        op("R5 byte 0 new",      1, 0, 12'd0, 0, 8'h00);
        op("R5 write 101",       0, 0, 12'd101, 1, 8'h44);
        op("R5 word 100 port B", 1, 1, 12'd100, 0, 8'h00);
        op("R7 byte 4094 with write", 1, 0, 12'd4094, 1, 8'h0F);
        op("R9 word 4094 new",   1, 1, 12'd4094, 0, 8'h00);
        op("R8 idle end",        0, 0, 12'd0, 0, 8'h00);
        op("R8 idle end 2",      0, 0, 12'd0, 0, 8'h00);

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule